// File: doc/BRIEF.md
# Packed Double-to-Single Floating-Point Converter

This unit narrows two IEEE-754 binary64 values, packed side by side in a 128-bit operand, into two IEEE-754 binary32 values. The two results sit in the low 64 bits of a 128-bit result. The high 64 bits of the result are always zero. Each lane rounds by an externally supplied two-bit rounding field. Each lane builds single subnormals where the value calls for them, saturates on overflow according to the rounding direction, and quiets NaNs. The five exception conditions are ORed across the two lanes and reported with the result.

A second path checks the operand's address for 16-byte alignment when the operand is marked as coming from memory. This fault indication does not depend on the data value. Every result, flag and fault is registered once, so the outputs appear one clock after the input strobe. Flags and the fault are held at zero whenever the output strobe is low.

Top module: `fp_pack_narrow`

## Requirements
- R1: Operand bits 63:0 convert into result bits 31:0, operand bits 127:64 convert into result bits 63:32, and result bits 127:64 are always zero.
- R2: After a synchronous active-low reset, out_valid, result, exc_flags and align_fault are all zero.
- R3: out_valid equals in_valid of the previous clock. While out_valid is low, exc_flags and align_fault are zero.
- R4: The rounding field selects 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero. An inexact lane is rounded by it and raises precision (exc_flags bit 4).
- R5: If the rounded magnitude would reach 2^128, the lane raises overflow (bit 2) and precision. It returns infinity under nearest-even, and under the directed mode that points away from zero for the value's sign. Otherwise it returns the largest finite single value with that sign.
- R6: Values below 2^-126 become correctly rounded single subnormals, zero, or the smallest normal. Underflow (bit 3) is raised only when the value is below 2^-126 before rounding and the result is inexact.
- R7: A NaN input returns sign, exponent all ones, quiet bit 22 set, and result bits 21:0 taken from input fraction bits 50:29. Invalid (bit 0) is raised only when input fraction bit 51 is clear.
- R8: Denormal (bit 1) is raised when a lane's input has exponent zero and a nonzero fraction. Such inputs are converted like any other tiny value.
- R9: Signed zeros and signed infinities convert exactly and raise no flag.
- R10: align_fault is raised with the result when src_is_mem was set and addr_lo bits 3:0 were nonzero, whatever the data. A register source never faults.
- R11: Each exc_flags bit is the OR of that condition over both lanes. The bit order is 0 invalid, 1 denormal, 2 overflow, 3 underflow, 4 precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src_data | input | 128 | Two packed binary64 values |
| rnd_mode | input | 2 | Rounding direction field |
| src_is_mem | input | 1 | Operand fetched from memory |
| addr_lo | input | 4 | Low address bits of a memory operand |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 128 | Two packed binary32 values, high half zero |
| exc_flags | output | 5 | Exception flags ORed over lanes |
| align_fault | output | 1 | Misaligned memory operand |

## Verification
The assertions assume that every input is free of unknowns once reset has been released. They also assume that inputs change only between clock edges, so that each $past value is the operand that was actually registered. The stimulus meets both conditions. It drives every input on the falling edge, holds it for a whole cycle, and assigns defined values during reset. Its random operands keep many exponents near the subnormal and overflow boundaries, so the properties on underflow, overflow and NaN handling are exercised by real cases.

// File: rtl/fpn_pkg.sv
// Package: shared formats, flag bit positions and the rounding field encoding
// for the packed double-to-single converter. Assumes IEEE-754 binary64/binary32.
package fpn_pkg;

    localparam int DP_W     = 64;
    localparam int DP_EXP_W = 11;
    localparam int DP_FRC_W = 52;
    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_FRC_W = 23;
    localparam int FLAG_W   = 5;

    // Exponent bias difference between the formats (1023 - 127).
    localparam int BIAS_GAP = 896;
    // Fraction bits dropped on a normal-range narrowing.
    localparam int DROP_W   = DP_FRC_W - SP_FRC_W;

    // Flag bit positions on exc_flags.
    localparam int FLG_INV = 0;
    localparam int FLG_DEN = 1;
    localparam int FLG_OVF = 2;
    localparam int FLG_UNF = 3;
    localparam int FLG_PRE = 4;

    // Rounding direction encoding.
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_TRUNC     = 2'b11
    } rnd_mode_e;

    localparam logic [SP_W-2:0] SP_INF_MAG = 31'h7F80_0000;
    localparam logic [SP_W-2:0] SP_MAX_MAG = 31'h7F7F_FFFF;

endpackage

// File: rtl/fpn_round_dec.sv
// Rounding decision: tells whether a truncated magnitude must be bumped by one
// unit in the last place. Assumes guard/sticky describe the discarded bits.
module fpn_round_dec
    import fpn_pkg::*;
(
    input  logic [1:0] rmode,
    input  logic       sign,
    input  logic       lsb,
    input  logic       guard,
    input  logic       sticky,
    output logic       bump
);

    // Select the increment rule for the requested direction.
    always_comb begin
        unique case (rnd_mode_e'(rmode))
            RM_NEAR_EVEN: bump = guard & (sticky | lsb);
            RM_DOWN:      bump = sign & (guard | sticky);
            RM_UP:        bump = ~sign & (guard | sticky);
            default:      bump = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpn_lane.sv
// One conversion lane: binary64 in, binary32 out plus five raw exception bits.
// Purely combinational. Tininess is judged before rounding. NaN payloads keep
// their top bits, and the sign is kept on every class of input.
module fpn_lane
    import fpn_pkg::*;
(
    input  logic [DP_W-1:0]   din,
    input  logic [1:0]        rmode,
    output logic [SP_W-1:0]   dout,
    output logic [FLAG_W-1:0] flags
);

    localparam int MANT_W  = DP_FRC_W + 1;
    localparam int EW      = 13;
    localparam int SH_W    = 6;
    localparam int SH_MAX  = 63;
    localparam int SIG_W   = SP_FRC_W + 2;

    logic                  sgn;
    logic [DP_EXP_W-1:0]   exp_in;
    logic [DP_FRC_W-1:0]   frc_in;
    logic                  exp_all1;
    logic                  exp_zero;
    logic [DP_EXP_W-1:0]   exp_eff;
    logic signed [EW-1:0]  sp_be;
    logic signed [EW-1:0]  sh_wide;
    logic [SH_W-1:0]       sh;
    logic [63:0]           mant64;
    logic [63:0]           kept;
    logic [63:0]           low_mask;
    logic                  grd;
    logic                  stk;
    logic                  bump;
    logic [SIG_W-1:0]      rnd_sig;
    logic signed [EW-1:0]  fin_e;
    logic                  tiny;
    logic                  ovf;
    logic                  inexact;
    logic                  go_inf;

    // Split the operand into its fields.
    always_comb begin
        sgn      = din[DP_W-1];
        exp_in   = din[DP_W-2 -: DP_EXP_W];
        frc_in   = din[DP_FRC_W-1:0];
        exp_all1 = &exp_in;
        exp_zero = ~|exp_in;
        exp_eff  = exp_zero ? DP_EXP_W'(1) : exp_in;
    end

    // Rebias the exponent and pick the right shift that aligns the significand.
    always_comb begin
        sp_be   = $signed({2'b00, exp_eff}) - EW'(BIAS_GAP);
        tiny    = sp_be < EW'(1);
        sh_wide = tiny ? (EW'(DROP_W + 1) - sp_be) : EW'(DROP_W);
        sh      = (sh_wide > EW'(SH_MAX)) ? SH_W'(SH_MAX) : sh_wide[SH_W-1:0];
    end

    // Shift the significand and collect the guard and sticky bits.
    always_comb begin
        mant64   = {{(64-MANT_W){1'b0}}, ~exp_zero, frc_in};
        kept     = mant64 >> sh;
        grd      = mant64[sh - SH_W'(1)];
        low_mask = (64'd1 << (sh - SH_W'(1))) - 64'd1;
        stk      = |(mant64 & low_mask);
        inexact  = grd | stk;
    end

    fpn_round_dec u_rdec (
        .rmode  (rmode),
        .sign   (sgn),
        .lsb    (kept[0]),
        .guard  (grd),
        .sticky (stk),
        .bump   (bump)
    );

    // Apply the rounding increment and detect exponent overflow.
    always_comb begin
        rnd_sig = kept[SIG_W-1:0] + SIG_W'(bump);
        fin_e   = sp_be + $signed({{(EW-1){1'b0}}, rnd_sig[SIG_W-1]});
        ovf     = ~tiny & (fin_e >= EW'(255));
        go_inf  = (rnd_mode_e'(rmode) == RM_NEAR_EVEN)
                | ((rnd_mode_e'(rmode) == RM_DOWN) & sgn)
                | ((rnd_mode_e'(rmode) == RM_UP) & ~sgn);
    end

    // Choose the packed result and the raw flags for each input class.
    always_comb begin
        dout  = '0;
        flags = '0;
        if (exp_all1) begin
            if (|frc_in) begin
                dout           = {sgn, {SP_EXP_W{1'b1}}, 1'b1, frc_in[DP_FRC_W-2 -: SP_FRC_W-1]};
                flags[FLG_INV] = ~frc_in[DP_FRC_W-1];
            end else begin
                dout = {sgn, SP_INF_MAG};
            end
        end else if (exp_zero && !(|frc_in)) begin
            dout = {sgn, {(SP_W-1){1'b0}}};
        end else begin
            flags[FLG_DEN] = exp_zero;
            if (ovf) begin
                dout           = {sgn, go_inf ? SP_INF_MAG : SP_MAX_MAG};
                flags[FLG_OVF] = 1'b1;
                flags[FLG_PRE] = 1'b1;
            end else if (tiny) begin
                dout           = {sgn, {(SP_EXP_W-1){1'b0}}, rnd_sig[SP_FRC_W], rnd_sig[SP_FRC_W-1:0]};
                flags[FLG_UNF] = inexact;
                flags[FLG_PRE] = inexact;
            end else begin
                dout           = {sgn, fin_e[SP_EXP_W-1:0], rnd_sig[SP_FRC_W-1:0]};
                flags[FLG_PRE] = inexact;
            end
        end
    end

endmodule

// File: rtl/fpn_align_chk.sv
// Alignment check for memory operands: flags any nonzero address bit below
// the required boundary. Assumes ALIGN_BYTES is a power of two.
module fpn_align_chk #(
    parameter int ADDR_W      = 4,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              is_mem,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault
);

    localparam int LOW_W = $clog2(ALIGN_BYTES);

    // Fault when a memory operand has any low address bit set.
    always_comb begin
        fault = is_mem & (|addr[LOW_W-1:0]);
    end

endmodule

// File: rtl/fp_pack_narrow.sv
// Top: two binary64 lanes narrowed to binary32, packed into the low half of a
// 128-bit result, flags ORed over lanes, one register stage. Assumes inputs
// are sampled only when in_valid is high.
module fp_pack_narrow
    import fpn_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int ADDR_W      = 4,
    parameter int ALIGN_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*DP_W-1:0]   src_data,
    input  logic [1:0]              rnd_mode,
    input  logic                    src_is_mem,
    input  logic [ADDR_W-1:0]       addr_lo,
    output logic                    out_valid,
    output logic [LANES*DP_W-1:0]   result,
    output logic [FLAG_W-1:0]       exc_flags,
    output logic                    align_fault
);

    localparam int PACK_W = LANES * SP_W;
    localparam int DATA_W = LANES * DP_W;

    logic [SP_W-1:0]   lane_out [LANES];
    logic [FLAG_W-1:0] lane_flg [LANES];
    logic [PACK_W-1:0] packed_c;
    logic [FLAG_W-1:0] flags_c;
    logic              fault_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fpn_lane u_lane (
            .din   (src_data[g*DP_W +: DP_W]),
            .rmode (rnd_mode),
            .dout  (lane_out[g]),
            .flags (lane_flg[g])
        );
    end

    fpn_align_chk #(
        .ADDR_W      (ADDR_W),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_align (
        .is_mem (src_is_mem),
        .addr   (addr_lo),
        .fault  (fault_c)
    );

    // Pack lane results and merge lane flags.
    always_comb begin
        packed_c = '0;
        flags_c  = '0;
        for (int i = 0; i < LANES; i++) begin
            packed_c[i*SP_W +: SP_W] = lane_out[i];
            flags_c                  = flags_c | lane_flg[i];
        end
    end

    // Output register stage with flags qualified by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            exc_flags   <= '0;
            align_fault <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            exc_flags   <= in_valid ? flags_c : '0;
            align_fault <= in_valid & fault_c;
            if (in_valid) begin
                result <= {{(DATA_W-PACK_W){1'b0}}, packed_c};
            end
        end
    end

endmodule

// File: rtl/fpn_checker.sv
// Checker bound to the top: timing, strobe qualification, packing and
// flag-relationship properties.
module fpn_checker
    import fpn_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] src_data,
    input logic         src_is_mem,
    input logic [3:0]   addr_lo,
    input logic         out_valid,
    input logic [127:0] result,
    input logic [4:0]   exc_flags,
    input logic         align_fault
);

    // R1: high half of the result stays zero.
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        result[127:64] == 64'd0);

    // R3: output strobe follows input strobe by one clock.
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: flags and fault are quiet without a strobe.
    a_r3_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (exc_flags == 5'd0 && !align_fault));

    // R5: overflow always comes with precision.
    a_r5_ovf_prec: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flags[FLG_OVF] |-> exc_flags[FLG_PRE]);

    // R6: underflow always comes with precision.
    a_r6_unf_prec: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flags[FLG_UNF] |-> exc_flags[FLG_PRE]);

    // R7: a signaling NaN in lane 0 raises invalid.
    a_r7_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&src_data[62:52]) && !src_data[51] && (|src_data[50:0]))
        |=> exc_flags[FLG_INV]);

    // R9: a lane-0 zero converts to a signed zero.
    a_r9_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_data[62:0] == 63'd0)
        |=> result[31:0] == {$past(src_data[63]), 31'd0});

    // R10: fault tracks the memory flag and the low address bits.
    a_r10_align: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> align_fault == $past(src_is_mem && addr_lo != 4'd0));

endmodule

bind fp_pack_narrow fpn_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_data    (src_data),
    .src_is_mem  (src_is_mem),
    .addr_lo     (addr_lo),
    .out_valid   (out_valid),
    .result      (result),
    .exc_flags   (exc_flags),
    .align_fault (align_fault)
);

// File: tb/fp_pack_narrow_tb.sv
// Bench: directed corners plus seeded random operands, checked against a
// bit-serial reference model of the narrowing.
module fp_pack_narrow_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_data = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         src_is_mem = 1'b0;
    logic [3:0]   addr_lo = 4'd0;
    logic         out_valid;
    logic [127:0] result;
    logic [4:0]   exc_flags;
    logic         align_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_pack_narrow u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src_data    (src_data),
        .rnd_mode    (rnd_mode),
        .src_is_mem  (src_is_mem),
        .addr_lo     (addr_lo),
        .out_valid   (out_valid),
        .result      (result),
        .exc_flags   (exc_flags),
        .align_fault (align_fault)
    );

    // Reference: shift one bit at a time, then round in the magnitude-code space.
    function automatic logic [36:0] model_lane(logic [63:0] d, logic [1:0] rm);
        logic        sgn = d[63];
        int          e = int'(d[62:52]);
        logic [51:0] f = d[51:0];
        logic [63:0] sig;
        int          x;
        logic        g = 1'b0;
        logic        st = 1'b0;
        logic        big = 1'b0;
        logic        tiny;
        logic [30:0] code;
        logic        up;
        logic        inx;
        logic [4:0]  fl = '0;
        int          ex;
        if (e == 2047) begin
            if (f == 0) return {5'd0, sgn, 31'h7F80_0000};
            return {4'd0, ~f[51], sgn, 8'hFF, 1'b1, f[50:29]};
        end
        if (e == 0 && f == 0) return {5'd0, sgn, 31'd0};
        fl[1] = (e == 0);
        sig = (e == 0) ? {12'd0, f} : {11'd0, 1'b1, f};
        x   = ((e == 0) ? 1 : e) - 1075;
        while (sig >= 64'h100_0000 || x < -149) begin
            st  = st | g;
            g   = sig[0];
            sig = sig >> 1;
            x++;
        end
        tiny = sig < 64'h80_0000;
        if (!tiny) begin
            ex = x + 150;
            if (ex >= 255) begin
                code = 31'h7F7F_FFFF;
                g = 1'b1; st = 1'b1; big = 1'b1;
            end else begin
                code = {ex[7:0], sig[22:0]};
            end
        end else begin
            code = sig[30:0];
        end
        inx = g | st;
        case (rm)
            2'b00:   up = g & (st | code[0]);
            2'b01:   up = sgn & inx;
            2'b10:   up = ~sgn & inx;
            default: up = 1'b0;
        endcase
        code = code + 31'(up);
        fl[2] = big | (code == 31'h7F80_0000);
        fl[3] = tiny & inx;
        fl[4] = inx;
        return {fl, sgn, code};
    endfunction

    task automatic check_eq(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one operand, wait for the registered output, compare everything.
    task automatic run_vec(string tag, logic [127:0] data, logic [1:0] rm, logic mem, logic [3:0] addr);
        logic [36:0] l0;
        logic [36:0] l1;
        logic [127:0] exp_res;
        l0 = model_lane(data[63:0], rm);
        l1 = model_lane(data[127:64], rm);
        exp_res = {64'd0, l1[31:0], l0[31:0]};
        @(negedge clk);
        in_valid = 1'b1; src_data = data; rnd_mode = rm; src_is_mem = mem; addr_lo = addr;
        @(negedge clk);
        in_valid = 1'b0;
        check_eq(tag, "result", result, exp_res);
        check_eq(tag, "flags", 128'(exc_flags), 128'(l0[36:32] | l1[36:32]));
        check_eq(tag, "fault", 128'(align_fault), 128'(mem && addr != 4'd0));
        check_eq(tag, "valid", 128'(out_valid), 128'd1);
    endtask

    function automatic logic [63:0] rand_dp();
        int unsigned sel = $urandom_range(0, 9);
        logic [63:0] v = {$urandom, $urandom};
        int unsigned ev;
        case (sel)
            0, 1:    ev = $urandom_range(860, 905);
            2, 3:    ev = $urandom_range(1145, 1160);
            4:       ev = 0;
            5:       ev = 2047;
            6, 7:    ev = $urandom_range(896, 1150);
            default: ev = int'(v[62:52]);
        endcase
        v[62:52] = 11'(ev);
        if (sel == 9) v[28:0] = (v[0]) ? 29'h1000_0000 : 29'd0;
        return v;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R2: reset state
        check_eq("R2", "out_valid", 128'(out_valid), 128'd0);
        check_eq("R2", "result", result, 128'd0);
        check_eq("R2", "flags", 128'(exc_flags), 128'd0);
        check_eq("R2", "fault", 128'(align_fault), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: no strobe keeps outputs quiet
        check_eq("R3", "idle valid", 128'(out_valid), 128'd0);
        check_eq("R3", "idle flags", 128'(exc_flags), 128'd0);

        // R1: lane placement with upper half zero
        run_vec("R1", {64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000}, 2'b00, 1'b0, 4'd0);
        check_eq("R1", "packed", result, {64'd0, 32'hC000_0000, 32'h3F80_0000});
        // R4: halfway case under each direction
        for (int m = 0; m < 4; m++)
            run_vec("R4", {64'hBFF0_0000_1000_0000, 64'h3FF0_0000_1000_0000}, 2'(m), 1'b0, 4'd0);
        run_vec("R4", {64'h3FF0_0000_3000_0000, 64'h3FF0_0000_1000_0001}, 2'b00, 1'b0, 4'd0);
        // R5: overflow under each direction, both signs
        for (int m = 0; m < 4; m++)
            run_vec("R5", {64'hFE37_E43C_8800_759C, 64'h7E37_E43C_8800_759C}, 2'(m), 1'b0, 4'd0);
        run_vec("R5", {64'h0, 64'h47EF_FFFF_F000_0000}, 2'b00, 1'b0, 4'd0);
        // R6: smallest subnormal, tie to zero, carry into smallest normal
        run_vec("R6", {64'h36A0_0000_0000_0000, 64'h3690_0000_0000_0000}, 2'b00, 1'b0, 4'd0);
        run_vec("R6", {64'h36A0_0000_0000_0000, 64'h3690_0000_0000_0000}, 2'b10, 1'b0, 4'd0);
        run_vec("R6", {64'h380F_FFFF_F000_0000, 64'h380F_FFFF_E000_0000}, 2'b00, 1'b0, 4'd0);
        // R7: signaling and quiet NaNs
        run_vec("R7", {64'hFFF8_0000_2000_0000, 64'h7FF0_0000_0000_0001}, 2'b00, 1'b0, 4'd0);
        check_eq("R7", "nan values", result[63:0], {32'hFFC0_0001, 32'h7FC0_0000});
        check_eq("R7", "invalid", 128'(exc_flags[0]), 128'd1);
        // R8: double denormal input rounded up
        run_vec("R8", {64'h0000_0000_0000_0001, 64'h0}, 2'b10, 1'b0, 4'd0);
        check_eq("R8", "denormal flag", 128'(exc_flags), 128'h1A);
        // R9: signed zero and infinity
        run_vec("R9", {64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000}, 2'b01, 1'b0, 4'd0);
        check_eq("R9", "exact specials", result, {64'd0, 32'hFF80_0000, 32'h8000_0000});
        // R10: alignment cases
        run_vec("R10", {64'h0, 64'h3FF0_0000_0000_0000}, 2'b00, 1'b1, 4'h8);
        run_vec("R10", {64'h0, 64'h3FF0_0000_0000_0000}, 2'b00, 1'b1, 4'h0);
        run_vec("R10", {64'h0, 64'h3FF0_0000_0000_0000}, 2'b00, 1'b0, 4'h8);
        run_vec("R10", {64'h7FF0_0000_0000_0001, 64'h0}, 2'b00, 1'b1, 4'h1);
        // R11: flags from different lanes merge
        run_vec("R11", {64'h7FF0_0000_0000_0001, 64'h7E37_E43C_8800_759C}, 2'b00, 1'b0, 4'd0);
        check_eq("R11", "merged", 128'(exc_flags), 128'h15);
        // R3: strobe drops after a gap
        @(negedge clk);
        check_eq("R3", "gap valid", 128'(out_valid), 128'd0);
        check_eq("R3", "gap fault", 128'(align_fault), 128'd0);

        // R4: seeded random operands
        for (int n = 0; n < 3000; n++)
            run_vec("R4", {rand_dp(), rand_dp()}, 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule